// File: doc/BRIEF.md
# Link Sequence and Replay Transmitter

This block is the transmit half of a link-level reliability scheme. Each packet offered on the upstream valid/ready port receives a 12-bit sequence number in front of its payload and a 32-bit link CRC behind it. The framed result goes out on the downstream valid/ready port in the same cycle it is accepted. A copy of the payload is kept in a replay store addressed by the low bits of its sequence number.

Feedback arrives on a separate port as decoded link control packets. Each one is either a positive or a negative acknowledge and carries a sequence number. A positive acknowledge frees every stored packet up to and including the number it carries. A negative acknowledge frees the same range. It then resends every packet still held, oldest first, under its original number, and so with its original CRC. A replay timer starts the same full resend when nothing has been acknowledged for a programmable number of cycles while packets are outstanding.

The downstream frame is `{4'b0000, seq[11:0], payload, crc[31:0]}`, most significant field first. The CRC uses polynomial 0x04C11DB7 and starts at all ones. It is computed without bit reflection and without a final inversion, over the 16-bit sequence field and then the payload, most significant bit first.

Top module: `lnk_replay_tx`

## Requirements
- R1: After reset, with no packet offered, `dn_valid_o` is low and `up_ready_o` equals `dn_ready_i`. The first packet sent carries sequence 0.
- R2: Each newly accepted packet carries a sequence one above the previous new packet, modulo 4096, so 4095 is followed by 0. The sequence sits in frame bits [FRM_W-5 -: 12] and the payload directly below it.
- R3: The low 32 bits of every frame hold the CRC defined above, computed over the 16-bit sequence field and the payload.
- R4: When the number of unacknowledged packets equals the store depth (or 2048, whichever is smaller), `up_ready_o` is low and no new frame is offered.
- R5: Feedback with sequence N is acted on only if N lies between the last acknowledged sequence and the newest sent sequence, inclusive, modulo 4096. Otherwise it changes nothing: no packet is released and no replay starts.
- R6: A valid negative acknowledge releases packets up to N. It then resends every remaining packet in increasing sequence order with its original sequence, payload and CRC, starting the cycle after the feedback. `up_ready_o` stays low during a resend, and a stalled frame holds steady.
- R7: Resends do not advance the sequence counter. The first new packet after a replay gets the number following the last new packet.
- R8: With `timeout_i` non-zero, if packets are outstanding and none is released for `timeout_i` cycles, a full replay of all outstanding packets starts. A value of 0 disables the timer.
- R9: Outside a replay, a packet is accepted exactly when it goes out: `up_ready_o` follows `dn_ready_i` while the store has room.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timeout_i | input | TMR_W | Replay timer limit in cycles, 0 disables |
| up_valid_i | input | 1 | Upstream packet valid |
| up_ready_o | output | 1 | Upstream packet accepted |
| up_data_i | input | 8*PKT_BYTES | Upstream packet payload |
| dn_valid_o | output | 1 | Downstream frame valid |
| dn_ready_i | input | 1 | Downstream frame taken |
| dn_data_o | output | 16+8*PKT_BYTES+32 | Framed packet: sequence field, payload, CRC |
| fb_valid_i | input | 1 | Feedback indication present |
| fb_nak_i | input | 1 | 1 for negative acknowledge, 0 for positive |
| fb_seq_i | input | 12 | Sequence number carried by the feedback |

## Verification
The bench builds the block with a four-entry replay store, 4-byte payloads and an 8-bit timer limit. The small store makes the full-store stall reachable after four unacknowledged packets. The narrow timer lets the timeout replay and its disabled setting be checked in a few dozen cycles. With packets acknowledged one at a time, the 12-bit sequence can run through 4095 and wrap to 0 well inside the run. That exercises modulo arithmetic in the sequence counter, the acknowledge range test and the store indexing.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam int unsigned SEQ_W     = 12;
  localparam int unsigned SEQ_FLD_W = 16;
  localparam int unsigned CRC_W     = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam int unsigned SEQ_CAP   = 2048;
  typedef logic [SEQ_W-1:0] seq_t;
endpackage

// File: rtl/lrt_crc.sv
module lrt_crc #(
  parameter int unsigned IN_W = 48
) (
  input  logic [IN_W-1:0]             msg_i,
  output logic [lrt_pkg::CRC_W-1:0]   crc_o
);
  logic [lrt_pkg::CRC_W-1:0] c;
  logic                      fb;

  // bit-serial recurrence unrolled, msb first, no reflection, no final xor
  always_comb begin
    c  = '1;
    fb = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb = c[lrt_pkg::CRC_W-1] ^ msg_i[i];
      c  = {c[lrt_pkg::CRC_W-2:0], 1'b0};
      if (fb) c = c ^ lrt_pkg::CRC_POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/lrt_store.sv
module lrt_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PKT_W = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_idx_i,
  input  logic [PKT_W-1:0] wr_data_i,
  input  logic [AW-1:0]    rd_idx_i,
  output logic [PKT_W-1:0] rd_data_o
);
  logic [PKT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/lrt_ctrl.sv
module lrt_ctrl
  import lrt_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] timeout_i,
  input  logic             up_valid_i,
  output logic             up_ready_o,
  output logic             dn_valid_o,
  input  logic             dn_ready_i,
  input  logic             fb_valid_i,
  input  logic             fb_nak_i,
  input  seq_t             fb_seq_i,
  output logic             replay_o,
  output logic             push_o,
  output seq_t             wr_seq_o,
  output seq_t             rd_seq_o
);
  localparam int unsigned LIMIT = (DEPTH < SEQ_CAP) ? DEPTH : SEQ_CAP;
  localparam seq_t LIMIT_S = seq_t'(LIMIT);
  localparam seq_t ONE     = seq_t'(1);

  seq_t next_q, ack_q, rp_q;
  logic replay_q;
  logic [TMR_W-1:0] tmr_q;

  seq_t out_cnt, fb_dist, ack_nx, next_nx, rp_nx;
  logic fb_ok, rel, can_push, push, pop, fire, restart, replay_nx;
  logic [TMR_W-1:0] tmr_nx;

  always_comb begin
    out_cnt    = next_q - ack_q - ONE;
    fb_dist    = fb_seq_i - ack_q;
    fb_ok      = fb_valid_i && (fb_dist <= out_cnt);
    rel        = fb_ok && (fb_dist != '0);
    ack_nx     = fb_ok ? fb_seq_i : ack_q;
    can_push   = out_cnt < LIMIT_S;
    up_ready_o = !replay_q && dn_ready_i && can_push;
    dn_valid_o = replay_q || (up_valid_i && can_push);
    push       = up_valid_i && up_ready_o;
    pop        = replay_q && dn_ready_i;
    next_nx    = next_q + seq_t'(push);
    fire       = !replay_q && (timeout_i != '0) && (out_cnt != '0) && (tmr_q >= timeout_i);
    restart    = (fb_ok && fb_nak_i) || fire;
    rp_nx      = pop ? rp_q + ONE : rp_q;
    if (restart) rp_nx = ack_nx + ONE;
    // an acknowledge may overtake the replay pointer: skip released entries
    else if ((rp_nx - ack_nx - ONE) > (next_nx - ack_nx - ONE)) rp_nx = ack_nx + ONE;
    replay_nx  = (restart || replay_q) && (rp_nx != next_nx);
    if (replay_q || (out_cnt == '0) || rel || restart || (timeout_i == '0)) tmr_nx = '0;
    else tmr_nx = tmr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_q   <= '0;
      ack_q    <= '1;
      rp_q     <= '0;
      replay_q <= 1'b0;
      tmr_q    <= '0;
    end else begin
      next_q   <= next_nx;
      ack_q    <= ack_nx;
      rp_q     <= rp_nx;
      replay_q <= replay_nx;
      tmr_q    <= tmr_nx;
    end
  end

  assign replay_o = replay_q;
  assign push_o   = push;
  assign wr_seq_o = next_q;
  assign rd_seq_o = rp_q;

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_cnt <= LIMIT_S);
  assert_no_growth_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push |=> out_cnt <= $past(out_cnt));
  assert_stall_replay_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_q |-> !up_ready_o);
  assert_seq_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_q |=> next_q == $past(next_q));
endmodule

// File: rtl/lnk_replay_tx.sv
module lnk_replay_tx
  import lrt_pkg::*;
#(
  parameter int unsigned PKT_BYTES = 4,
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned TMR_W     = 16,
  localparam int unsigned PKT_W    = 8 * PKT_BYTES,
  localparam int unsigned MSG_W    = SEQ_FLD_W + PKT_W,
  localparam int unsigned FRM_W    = MSG_W + CRC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMR_W-1:0] timeout_i,
  input  logic             up_valid_i,
  output logic             up_ready_o,
  input  logic [PKT_W-1:0] up_data_i,
  output logic             dn_valid_o,
  input  logic             dn_ready_i,
  output logic [FRM_W-1:0] dn_data_o,
  input  logic             fb_valid_i,
  input  logic             fb_nak_i,
  input  logic [SEQ_W-1:0] fb_seq_i
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic replay, push;
  seq_t wr_seq, rd_seq, out_seq;
  logic [PKT_W-1:0] rd_data, out_pay;
  logic [MSG_W-1:0] msg;
  logic [CRC_W-1:0] crc;

  lrt_ctrl #(.DEPTH(DEPTH), .TMR_W(TMR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .timeout_i  (timeout_i),
    .up_valid_i (up_valid_i),
    .up_ready_o (up_ready_o),
    .dn_valid_o (dn_valid_o),
    .dn_ready_i (dn_ready_i),
    .fb_valid_i (fb_valid_i),
    .fb_nak_i   (fb_nak_i),
    .fb_seq_i   (fb_seq_i),
    .replay_o   (replay),
    .push_o     (push),
    .wr_seq_o   (wr_seq),
    .rd_seq_o   (rd_seq)
  );

  lrt_store #(.DEPTH(DEPTH), .PKT_W(PKT_W)) u_store (
    .clk_i     (clk_i),
    .wr_en_i   (push),
    .wr_idx_i  (wr_seq[AW-1:0]),
    .wr_data_i (up_data_i),
    .rd_idx_i  (rd_seq[AW-1:0]),
    .rd_data_o (rd_data)
  );

  assign out_seq = replay ? rd_seq : wr_seq;
  assign out_pay = replay ? rd_data : up_data_i;
  assign msg     = {{(SEQ_FLD_W-SEQ_W){1'b0}}, out_seq, out_pay};

  lrt_crc #(.IN_W(MSG_W)) u_crc (
    .msg_i (msg),
    .crc_o (crc)
  );

  assign dn_data_o = {msg, crc};

  assert_replay_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay && !dn_ready_i && !fb_valid_i) |=> $stable(dn_data_o) && dn_valid_o);
endmodule

// File: tb/sim_lnk_replay_tx.sv
module sim_lnk_replay_tx;
  localparam int unsigned PB = 4;
  localparam int unsigned DP = 4;
  localparam int unsigned TW = 8;
  localparam int unsigned FW = 16 + 8*PB + 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [TW-1:0] timeout = '0;
  logic up_valid = 1'b0, up_ready;
  logic [31:0] up_data = '0;
  logic dn_valid, dn_ready = 1'b0;
  logic [FW-1:0] dn_data;
  logic fb_valid = 1'b0, fb_nak = 1'b0;
  logic [11:0] fb_seq = '0;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lnk_replay_tx #(.PKT_BYTES(PB), .DEPTH(DP), .TMR_W(TW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .timeout_i(timeout),
    .up_valid_i(up_valid), .up_ready_o(up_ready), .up_data_i(up_data),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_data_o(dn_data),
    .fb_valid_i(fb_valid), .fb_nak_i(fb_nak), .fb_seq_i(fb_seq)
  );

  // stimulus table: expected sequence and payload
  localparam logic [43:0] TBL [6] = '{
    {12'd0, 32'h00000000}, {12'd1, 32'hFFFFFFFF}, {12'd2, 32'hA5A5A5A5},
    {12'd3, 32'h12345678}, {12'd4, 32'h80000001}, {12'd5, 32'hDEADBEEF}
  };

  function automatic logic [31:0] crc_ref(input logic [11:0] s, input logic [31:0] p);
    logic [47:0] m;
    logic [31:0] c;
    logic b;
    m = {4'b0000, s, p};
    c = 32'hFFFFFFFF;
    for (int i = 47; i >= 0; i--) begin
      b = c[31] ^ m[i];
      c = {c[30:0], 1'b0};
      if (b) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic chk_frame(input string rq, input logic [11:0] s, input logic [31:0] p);
    chk({rq, " valid"}, dn_valid, 1);
    chk({rq, " seq"}, dn_data[79:64], {4'b0000, s});
    chk({rq, " payload"}, dn_data[63:32], p);
    chk({"R3 crc/", rq}, dn_data[31:0], crc_ref(s, p));
  endtask

  task automatic send_pkt(input logic [31:0] p, input logic [11:0] s, input string rq);
    @(negedge clk);
    up_valid = 1'b1; up_data = p; dn_ready = 1'b1;
    #1;
    chk("R9 ready", up_ready, 1);
    chk_frame(rq, s, p);
    @(posedge clk); #1;
    up_valid = 1'b0;
  endtask

  task automatic send_fb(input logic nak, input logic [11:0] s);
    @(negedge clk);
    fb_valid = 1'b1; fb_nak = nak; fb_seq = s;
    @(posedge clk); #1;
    fb_valid = 1'b0;
  endtask

  task automatic exp_beat(input logic [11:0] s, input logic [31:0] p);
    @(negedge clk);
    dn_ready = 1'b1;
    #1;
    chk_frame("R6 replay", s, p);
    chk("R6 stall", up_ready, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    // R1 reset state
    repeat (3) @(negedge clk);
    dn_ready = 1'b1;
    #1;
    chk("R1 valid in reset", dn_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 idle valid", dn_valid, 0);
    chk("R1 idle ready", up_ready, 1);
    dn_ready = 1'b0; #1;
    chk("R9 ready follows dn_ready", up_ready, 0);

    // table walk: R1 first seq 0, R2 increment, R3 crc
    foreach (TBL[i]) begin
      send_pkt(TBL[i][31:0], TBL[i][43:32], "R2 table");
      send_fb(1'b0, TBL[i][43:32]);
    end

    // R4 fill the store
    for (int k = 6; k < 10; k++) send_pkt(32'h1000_0000 + k, 12'(k), "R2 fill");
    @(negedge clk);
    up_valid = 1'b1; up_data = 32'h5555_5555; #1;
    chk("R4 full ready", up_ready, 0);
    chk("R4 full valid", dn_valid, 0);
    @(negedge clk); up_valid = 1'b0;

    // R5 stale and out-of-range feedback ignored
    send_fb(1'b0, 12'd5);
    send_fb(1'b0, 12'd100);
    send_fb(1'b1, 12'd200);
    @(negedge clk); #1;
    chk("R5 still full", up_ready, 0);
    chk("R5 no replay", dn_valid, 0);
    send_fb(1'b0, 12'd7);
    @(negedge clk); #1;
    chk("R5 ack releases two", up_ready, 1);

    // R6 nak on last acked: replay 8,9 with a stall first
    send_fb(1'b1, 12'd7);
    @(negedge clk); dn_ready = 1'b0; #1;
    chk("R6 stalled valid", dn_valid, 1);
    chk("R6 stalled seq", dn_data[79:64], 16'd8);
    @(negedge clk); #1;
    chk("R6 hold seq", dn_data[79:64], 16'd8);
    chk("R6 hold ready", up_ready, 0);
    exp_beat(12'd8, 32'h1000_0008);
    exp_beat(12'd9, 32'h1000_0009);
    send_pkt(32'hCAFE_0010, 12'd10, "R7 after replay");

    // R5 out-of-range nak, then R6 nak releasing one
    send_fb(1'b1, 12'd11);
    @(negedge clk); #1;
    chk("R5 bad nak no replay", dn_valid, 0);
    send_fb(1'b1, 12'd8);
    exp_beat(12'd9, 32'h1000_0009);
    exp_beat(12'd10, 32'hCAFE_0010);
    @(negedge clk); #1;
    chk("R6 replay done", dn_valid, 0);
    send_fb(1'b0, 12'd10);

    // R8 replay timer
    @(negedge clk); timeout = 8'd20;
    send_pkt(32'h7777_0011, 12'd11, "R2 timer pkt");
    seen = 1'b0;
    repeat (15) begin @(negedge clk); #1; if (dn_valid) seen = 1'b1; end
    chk("R8 no early replay", seen, 0);
    seen = 1'b0;
    for (int w = 0; w < 30 && !seen; w++) begin
      @(negedge clk); #1;
      if (dn_valid) seen = 1'b1;
    end
    chk("R8 timer replay", seen, 1);
    chk_frame("R8 timer", 12'd11, 32'h7777_0011);
    @(posedge clk); #1;
    send_fb(1'b0, 12'd11);
    @(negedge clk); timeout = 8'd0;
    send_pkt(32'h7777_0012, 12'd12, "R2 timer off pkt");
    seen = 1'b0;
    repeat (100) begin @(negedge clk); #1; if (dn_valid) seen = 1'b1; end
    chk("R8 disabled", seen, 0);
    send_fb(1'b0, 12'd12);

    // R2 wrap through 4095 to 0
    for (int s = 13; s < 4096 + 3; s++) begin
      send_pkt(32'h0BAD_0000 ^ s, 12'(s), "R2 wrap");
      send_fb(1'b0, 12'(s));
    end
    @(negedge clk); #1;
    chk("R5 ack after wrap", up_ready, 1);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule